// File: doc/BRIEF.md
# Ethernet MAC Configuration Register File

This block is the software-visible settings bank of a tri-speed Ethernet MAC. A 32-bit word-addressed port writes and reads the settings. The block holds a read-only version word, a scratch word, the command word, the station address, the frame-length limit, the pause and holdoff quanta, eight FIFO thresholds, two PHY management addresses and the minimum inter-packet gap. Every value is decoded and driven straight out to the MAC datapath as plain configuration pins.

Several register values are reinterpreted on the way out. The station address is stored byte-reversed across two words and is presented on the output in wire order. An out-of-range gap setting falls back to a safe default, but a read still returns the raw value that was written. The transmit almost-full threshold is turned into a clamped ready-latency count. A soft-reset pin stops traffic by clearing only the two enable bits.

The `REDUCED` build parameter selects a cut-down variant. In that variant the frame length, all FIFO thresholds and the gap are fixed constants, and the scratch word does not exist. The register port is a plain strobe interface with no back-pressure. Each write completes in its own cycle. A read answers exactly one cycle after it is issued, and the response cannot be stalled.

Top module: `ethcfg_regs`

## Requirements
- R1: When `rd_en` is high at a clock edge, `rd_data` and `rd_valid` update at that same edge. `rd_data` holds the word at `addr` as it stood before any write in that cycle. `rd_valid` is high in exactly the cycle after each `rd_en` cycle.
- R2: After hardware reset the following values read back: frame length (word 5) is 1518, second PHY address (word 16) is 1, holdoff (word 17) is 0xFFFF, and every other writable word is 0.
- R3: Only these bits are stored, and all other bits read as zero: PHY addresses (words 15 and 16) keep bits 4:0. Gap (word 23) keeps bits 4:0. Frame length (5), pause (6), holdoff (17) and address-high (4) keep bits 15:0. The eight thresholds (words 7 to 14) keep bits `THR_W`-1:0. Scratch (1), command (2) and address-low (3) keep all 32 bits.
- R4: Word 0 reads `{CUST_REV, IP_VERSION}`. Writes to word 0 are ignored.
- R5: Words 18 to 22 and 24 to 31 read as zero, and writes to them change nothing.
- R6: `soft_rst` clears command bits 0 (`tx_en`) and 1 (`rx_en`) and leaves every other bit of every register unchanged. If `soft_rst` and a command write occur in the same cycle, both bits end up cleared.
- R7: `station_addr[47:40]` is byte 0 of address-low. The bytes then follow in order: address-low bytes 1 to 3, then address-high bytes 0 and 1. For example, address-low 0x17231C00 with address-high 0x0000CB4A gives 0x001C23174ACB.
- R8: `ipg_eff` equals gap bits 4:0 when that value is in the range 8 to 26, and equals 12 otherwise. A read of word 23 returns the raw stored value.
- R9: `tx_ready_lat` is the tx almost-full threshold (word 14) minus 3, with the threshold first clamped to the range 3 to 11. Readback of word 14 returns the raw stored value.
- R10: With `REDUCED`=1, these words read as fixed values and ignore writes: word 5 = 1518, words 7 and 9 = `FIFO_DEPTH`-16, words 8 and 10 = 16, words 11, 12 and 13 = 8, word 14 = 3, and word 23 = 12. The decoded outputs follow these fixed values.
- R11: With `REDUCED`=1, word 1 (scratch) reads as zero and ignores writes.
- R12: A write to a word changes the matching decoded output at the clock edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | Clears the transmit and receive enables |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read response strobe |
| tx_en | output | 1 | Transmit enable (command bit 0) |
| rx_en | output | 1 | Receive enable (command bit 1) |
| cmd_word | output | 32 | Full command word |
| station_addr | output | 48 | Station address in wire byte order |
| max_frm_len | output | 16 | Frame-length limit |
| pause_quanta | output | 16 | Pause quanta |
| rx_sec_empty | output | THR_W | Rx section-empty threshold |
| rx_sec_full | output | THR_W | Rx section-full threshold |
| tx_sec_empty | output | THR_W | Tx section-empty threshold |
| tx_sec_full | output | THR_W | Tx section-full threshold |
| rx_alm_empty | output | THR_W | Rx almost-empty threshold |
| rx_alm_full | output | THR_W | Rx almost-full threshold |
| tx_alm_empty | output | THR_W | Tx almost-empty threshold |
| tx_alm_full | output | THR_W | Tx almost-full threshold, raw |
| tx_ready_lat | output | 4 | Effective ready latency, 0 to 8 |
| phy_addr0 | output | 5 | First PHY management address |
| phy_addr1 | output | 5 | Second PHY management address |
| holdoff_quanta | output | 16 | Gap between XOFF requests |
| ipg_eff | output | 5 | Effective minimum gap |

## Verification
On every cycle the assertions check four things:
- The one-cycle read-response timing and the version and reserved-word read values.
- That a soft reset drops both enables while leaving the address and frame-length outputs untouched.
- That the effective gap stays within 8 to 26.
- That the ready latency never exceeds 8.

The bench's sweeps are the only evidence for the rest. They cover every bit mask and reset value across all 32 addresses in both variants, and the full fallback table for all 32 gap codes. They also cover the latency clamp across 16 threshold values, the byte-reversed address example, read-before-write ordering, and soft reset racing a command write.

// File: rtl/ethcfg_pkg.sv
package ethcfg_pkg;
  typedef logic [31:0] word_t;

  localparam int NWORDS  = 24;
  localparam int A_REV   = 0;
  localparam int A_SCR   = 1;
  localparam int A_CMD   = 2;
  localparam int A_SALO  = 3;
  localparam int A_SAHI  = 4;
  localparam int A_FRM   = 5;
  localparam int A_PAUSE = 6;
  localparam int A_RXSE  = 7;
  localparam int A_RXSF  = 8;
  localparam int A_TXSE  = 9;
  localparam int A_TXSF  = 10;
  localparam int A_RXAE  = 11;
  localparam int A_RXAF  = 12;
  localparam int A_TXAE  = 13;
  localparam int A_TXAF  = 14;
  localparam int A_PHY0  = 15;
  localparam int A_PHY1  = 16;
  localparam int A_HOLD  = 17;
  localparam int A_IPG   = 23;

  localparam int FRM_DEFAULT = 1518;
  localparam int IPG_DEFAULT = 12;

  // registers that become constants in the reduced build
  function automatic bit is_locked(int idx);
    return idx == A_FRM || (idx >= A_RXSE && idx <= A_TXAF) || idx == A_IPG;
  endfunction

  function automatic word_t wr_mask(int idx, bit reduced, int thr_w);
    word_t thr;
    thr = word_t'((64'd1 << thr_w) - 64'd1);
    if (reduced && (is_locked(idx) || idx == A_SCR)) return '0;
    case (idx)
      A_SCR, A_CMD, A_SALO:           return '1;
      A_SAHI, A_FRM, A_PAUSE, A_HOLD: return 32'h0000_FFFF;
      A_PHY0, A_PHY1, A_IPG:          return 32'h0000_001F;
      default: begin
        if (idx >= A_RXSE && idx <= A_TXAF) return thr;
        return '0;
      end
    endcase
  endfunction

  function automatic word_t rst_value(int idx);
    case (idx)
      A_FRM:   return word_t'(FRM_DEFAULT);
      A_PHY1:  return 32'd1;
      A_HOLD:  return 32'h0000_FFFF;
      default: return '0;
    endcase
  endfunction

  function automatic word_t fixed_value(int idx, int depth);
    case (idx)
      A_FRM:                    return word_t'(FRM_DEFAULT);
      A_RXSE, A_TXSE:           return word_t'(depth - 16);
      A_RXSF, A_TXSF:           return 32'd16;
      A_RXAE, A_RXAF, A_TXAE:   return 32'd8;
      A_TXAF:                   return 32'd3;
      A_IPG:                    return word_t'(IPG_DEFAULT);
      default:                  return '0;
    endcase
  endfunction

  function automatic logic [4:0] gap_effective(logic [4:0] raw);
    if (raw >= 5'd8 && raw <= 5'd26) return raw;
    return 5'(IPG_DEFAULT);
  endfunction

  function automatic logic [3:0] latency_from_thr(word_t raw);
    if (raw < 32'd3)  return 4'd0;
    if (raw > 32'd11) return 4'd8;
    return 4'(raw - 32'd3);
  endfunction
endpackage

// File: rtl/ethcfg_store.sv
module ethcfg_store
  import ethcfg_pkg::*;
#(
  parameter bit REDUCED = 1'b0,
  parameter int THR_W   = 16,
  parameter int ADDR_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic [31:0]              wr_data,
  output logic [NWORDS-1:0][31:0]  regs_q
);
  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam word_t MASK = wr_mask(i, REDUCED, THR_W);
    localparam word_t RSTV = rst_value(i) & MASK;
    if (MASK == '0) begin : g_const
      assign regs_q[i] = '0;
    end else begin : g_flop
      word_t word_q;
      logic  hit;
      assign hit = wr_en && (addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= RSTV;
        end else begin
          if (hit) word_q <= (word_q & ~MASK) | (wr_data & MASK);
          if (i == A_CMD && soft_rst) word_q[1:0] <= 2'b00;
        end
      end
      assign regs_q[i] = word_q;
    end
  end
endmodule

// File: rtl/ethcfg_view.sv
module ethcfg_view
  import ethcfg_pkg::*;
#(
  parameter bit          REDUCED    = 1'b0,
  parameter int          FIFO_DEPTH = 64,
  parameter logic [15:0] IP_VERSION = 16'h0A13,
  parameter logic [15:0] CUST_REV   = 16'h0005
) (
  input  logic [NWORDS-1:0][31:0] regs_q,
  output logic [NWORDS-1:0][31:0] view
);
  for (genvar i = 0; i < NWORDS; i++) begin : g_view
    if (i == A_REV) begin : g_rev
      assign view[i] = {CUST_REV, IP_VERSION};
    end else if (REDUCED && is_locked(i)) begin : g_fixed
      assign view[i] = fixed_value(i, FIFO_DEPTH);
    end else begin : g_live
      assign view[i] = regs_q[i];
    end
  end
endmodule

// File: rtl/ethcfg_decode.sv
module ethcfg_decode
  import ethcfg_pkg::*;
#(
  parameter int THR_W = 16
) (
  input  logic [NWORDS-1:0][31:0] view,
  output logic                    tx_en,
  output logic                    rx_en,
  output logic [31:0]             cmd_word,
  output logic [47:0]             station_addr,
  output logic [15:0]             max_frm_len,
  output logic [15:0]             pause_quanta,
  output logic [THR_W-1:0]        rx_sec_empty,
  output logic [THR_W-1:0]        rx_sec_full,
  output logic [THR_W-1:0]        tx_sec_empty,
  output logic [THR_W-1:0]        tx_sec_full,
  output logic [THR_W-1:0]        rx_alm_empty,
  output logic [THR_W-1:0]        rx_alm_full,
  output logic [THR_W-1:0]        tx_alm_empty,
  output logic [THR_W-1:0]        tx_alm_full,
  output logic [3:0]              tx_ready_lat,
  output logic [4:0]              phy_addr0,
  output logic [4:0]              phy_addr1,
  output logic [15:0]             holdoff_quanta,
  output logic [4:0]              ipg_eff
);
  word_t lo, hi;
  logic  unused_bits;
  assign lo = view[A_SALO];
  assign hi = view[A_SAHI];
  assign unused_bits = ^view;

  assign cmd_word       = view[A_CMD];
  assign tx_en          = view[A_CMD][0];
  assign rx_en          = view[A_CMD][1];
  // first wire byte sits in the lowest byte of the low word
  assign station_addr   = {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
  assign max_frm_len    = view[A_FRM][15:0];
  assign pause_quanta   = view[A_PAUSE][15:0];
  assign rx_sec_empty   = view[A_RXSE][THR_W-1:0];
  assign rx_sec_full    = view[A_RXSF][THR_W-1:0];
  assign tx_sec_empty   = view[A_TXSE][THR_W-1:0];
  assign tx_sec_full    = view[A_TXSF][THR_W-1:0];
  assign rx_alm_empty   = view[A_RXAE][THR_W-1:0];
  assign rx_alm_full    = view[A_RXAF][THR_W-1:0];
  assign tx_alm_empty   = view[A_TXAE][THR_W-1:0];
  assign tx_alm_full    = view[A_TXAF][THR_W-1:0];
  assign tx_ready_lat   = latency_from_thr(view[A_TXAF]);
  assign phy_addr0      = view[A_PHY0][4:0];
  assign phy_addr1      = view[A_PHY1][4:0];
  assign holdoff_quanta = view[A_HOLD][15:0];
  assign ipg_eff        = gap_effective(view[A_IPG][4:0]);
endmodule

// File: rtl/ethcfg_regs.sv
module ethcfg_regs
  import ethcfg_pkg::*;
#(
  parameter bit          REDUCED    = 1'b0,
  parameter int          FIFO_DEPTH = 64,
  parameter int          THR_W      = 16,
  parameter int          ADDR_W     = 5,
  parameter logic [15:0] IP_VERSION = 16'h0A13,
  parameter logic [15:0] CUST_REV   = 16'h0005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              tx_en,
  output logic              rx_en,
  output logic [31:0]       cmd_word,
  output logic [47:0]       station_addr,
  output logic [15:0]       max_frm_len,
  output logic [15:0]       pause_quanta,
  output logic [THR_W-1:0]  rx_sec_empty,
  output logic [THR_W-1:0]  rx_sec_full,
  output logic [THR_W-1:0]  tx_sec_empty,
  output logic [THR_W-1:0]  tx_sec_full,
  output logic [THR_W-1:0]  rx_alm_empty,
  output logic [THR_W-1:0]  rx_alm_full,
  output logic [THR_W-1:0]  tx_alm_empty,
  output logic [THR_W-1:0]  tx_alm_full,
  output logic [3:0]        tx_ready_lat,
  output logic [4:0]        phy_addr0,
  output logic [4:0]        phy_addr1,
  output logic [15:0]       holdoff_quanta,
  output logic [4:0]        ipg_eff
);
  logic [NWORDS-1:0][31:0] regs_q;
  logic [NWORDS-1:0][31:0] view;
  word_t                   rd_word;

  ethcfg_store #(.REDUCED(REDUCED), .THR_W(THR_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .regs_q(regs_q)
  );

  ethcfg_view #(.REDUCED(REDUCED), .FIFO_DEPTH(FIFO_DEPTH),
                .IP_VERSION(IP_VERSION), .CUST_REV(CUST_REV)) u_view (
    .regs_q(regs_q), .view(view)
  );

  ethcfg_decode #(.THR_W(THR_W)) u_decode (
    .view(view), .tx_en(tx_en), .rx_en(rx_en), .cmd_word(cmd_word),
    .station_addr(station_addr), .max_frm_len(max_frm_len), .pause_quanta(pause_quanta),
    .rx_sec_empty(rx_sec_empty), .rx_sec_full(rx_sec_full),
    .tx_sec_empty(tx_sec_empty), .tx_sec_full(tx_sec_full),
    .rx_alm_empty(rx_alm_empty), .rx_alm_full(rx_alm_full),
    .tx_alm_empty(tx_alm_empty), .tx_alm_full(tx_alm_full),
    .tx_ready_lat(tx_ready_lat), .phy_addr0(phy_addr0), .phy_addr1(phy_addr1),
    .holdoff_quanta(holdoff_quanta), .ipg_eff(ipg_eff)
  );

  // addresses past the map decode to zero
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NWORDS; i++)
      if (addr == ADDR_W'(i)) rd_word = view[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/ethcfg_chk.sv
module ethcfg_chk #(
  parameter int          ADDR_W     = 5,
  parameter logic [15:0] IP_VERSION = 16'h0A13,
  parameter logic [15:0] CUST_REV   = 16'h0005
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [31:0]       rd_data,
  input logic              rd_valid,
  input logic              tx_en,
  input logic              rx_en,
  input logic [47:0]       station_addr,
  input logic [15:0]       max_frm_len,
  input logic [4:0]        ipg_eff,
  input logic [3:0]        tx_ready_lat
);
  AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R1
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R1
  AST_REV_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == ADDR_W'(0) |=> rd_data == {CUST_REV, IP_VERSION}); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr >= ADDR_W'(18) && addr != ADDR_W'(23) |=> rd_data == 32'd0); // R5
  AST_SOFT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !tx_en && !rx_en); // R6
  AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !wr_en |=> $stable(station_addr) && $stable(max_frm_len)); // R6
  AST_GAP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ipg_eff >= 5'd8 && ipg_eff <= 5'd26); // R8
  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_lat <= 4'd8); // R9
endmodule

bind ethcfg_regs ethcfg_chk #(.ADDR_W(ADDR_W), .IP_VERSION(IP_VERSION), .CUST_REV(CUST_REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr), .wr_en(wr_en),
  .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .tx_en(tx_en), .rx_en(rx_en),
  .station_addr(station_addr), .max_frm_len(max_frm_len), .ipg_eff(ipg_eff),
  .tx_ready_lat(tx_ready_lat)
);

// File: tb/ethcfg_regs_tb.sv
`timescale 1ns/1ps
module ethcfg_regs_tb;
  localparam int          DEPTH = 64;
  localparam int          THRW  = 16;
  localparam logic [15:0] VER   = 16'h0A13;
  localparam logic [15:0] CREV  = 16'h0005;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [4:0] addr = '0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [31:0] wr_data = '0;

  logic [31:0] rd_f, rd_r, cmd_f, cmd_r;
  logic rv_f, rv_r, txe_f, txe_r, rxe_f, rxe_r;
  logic [47:0] sa_f, sa_r;
  logic [15:0] frm_f, frm_r, pq_f, pq_r, ho_f, ho_r;
  logic [THRW-1:0] t_f[8];
  logic [THRW-1:0] t_r[8];
  logic [3:0] lat_f, lat_r;
  logic [4:0] p0_f, p0_r, p1_f, p1_r, ipg_f, ipg_r;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ethcfg_regs #(.REDUCED(1'b0), .FIFO_DEPTH(DEPTH), .THR_W(THRW), .ADDR_W(5),
                .IP_VERSION(VER), .CUST_REV(CREV)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_f), .rd_valid(rv_f),
    .tx_en(txe_f), .rx_en(rxe_f), .cmd_word(cmd_f), .station_addr(sa_f),
    .max_frm_len(frm_f), .pause_quanta(pq_f),
    .rx_sec_empty(t_f[0]), .rx_sec_full(t_f[1]), .tx_sec_empty(t_f[2]), .tx_sec_full(t_f[3]),
    .rx_alm_empty(t_f[4]), .rx_alm_full(t_f[5]), .tx_alm_empty(t_f[6]), .tx_alm_full(t_f[7]),
    .tx_ready_lat(lat_f), .phy_addr0(p0_f), .phy_addr1(p1_f),
    .holdoff_quanta(ho_f), .ipg_eff(ipg_f)
  );

  ethcfg_regs #(.REDUCED(1'b1), .FIFO_DEPTH(DEPTH), .THR_W(THRW), .ADDR_W(5),
                .IP_VERSION(VER), .CUST_REV(CREV)) u_dut_red (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_r), .rd_valid(rv_r),
    .tx_en(txe_r), .rx_en(rxe_r), .cmd_word(cmd_r), .station_addr(sa_r),
    .max_frm_len(frm_r), .pause_quanta(pq_r),
    .rx_sec_empty(t_r[0]), .rx_sec_full(t_r[1]), .tx_sec_empty(t_r[2]), .tx_sec_full(t_r[3]),
    .rx_alm_empty(t_r[4]), .rx_alm_full(t_r[5]), .tx_alm_empty(t_r[6]), .tx_alm_full(t_r[7]),
    .tx_ready_lat(lat_r), .phy_addr0(p0_r), .phy_addr1(p1_r),
    .holdoff_quanta(ho_r), .ipg_eff(ipg_r)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit masks from R3, R5, R10, R11
  function automatic logic [31:0] exp_mask(int a, bit red);
    if (red && (a == 1 || a == 5 || (a >= 7 && a <= 14) || a == 23)) return 32'h0;
    if (a == 1 || a == 2 || a == 3) return 32'hFFFF_FFFF;
    if (a == 4 || a == 5 || a == 6 || a == 17) return 32'h0000_FFFF;
    if (a == 15 || a == 16 || a == 23) return 32'h0000_001F;
    if (a >= 7 && a <= 14) return (32'h1 << THRW) - 1;
    return 32'h0;
  endfunction

  // constant words from R4 and R10; returns 1 if the word is fixed
  function automatic bit exp_fixed(int a, bit red, output logic [31:0] v);
    v = 32'h0;
    if (a == 0) begin v = {CREV, VER}; return 1'b1; end
    if (!red) return 1'b0;
    case (a)
      5:          v = 32'd1518;
      7, 9:       v = DEPTH - 16;
      8, 10:      v = 32'd16;
      11, 12, 13: v = 32'd8;
      14:         v = 32'd3;
      23:         v = 32'd12;
      default:    return 1'b0;
    endcase
    return 1'b1;
  endfunction

  function automatic logic [31:0] exp_reset(int a, bit red);
    logic [31:0] v;
    if (exp_fixed(a, red, v)) return v;
    if (a == 5) return 32'd1518;
    if (a == 16) return 32'd1;
    if (a == 17) return 32'h0000_FFFF;
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_after(int a, bit red, logic [31:0] d);
    logic [31:0] v;
    if (exp_fixed(a, red, v)) return v;
    return d & exp_mask(a, red);
  endfunction

  task automatic do_write(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 5'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input int a);
    @(negedge clk);
    addr = 5'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R1 rd_valid full", 64'(rv_f), 64'd1);
    check("R1 rd_valid reduced", 64'(rv_r), 64'd1);
  endtask

  function automatic logic [4:0] exp_gap(int v);
    return (v >= 8 && v <= 26) ? 5'(v) : 5'd12;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_valid idle", 64'(rv_f), 64'd0);

    // R2 reset sweep over every address, both variants
    for (int a = 0; a < 32; a++) begin
      do_read(a);
      check("R2 reset full", 64'(rd_f), 64'(exp_reset(a, 1'b0)));
      check("R2 reset reduced", 64'(rd_r), 64'(exp_reset(a, 1'b1)));
    end
    check("R10 reduced ipg_eff", 64'(ipg_r), 64'd12);
    check("R10 reduced lat", 64'(lat_r), 64'd0);
    check("R10 reduced rx_sec_empty", 64'(t_r[0]), 64'(DEPTH - 16));

    // R3 R4 R5 R10 R11 mask sweep with all-ones then zero
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 32; a++) begin
        logic [31:0] d;
        d = (p == 0) ? 32'hFFFF_FFFF : 32'h0;
        do_write(a, d);
        do_read(a);
        check("R3 mask full", 64'(rd_f), 64'(exp_after(a, 1'b0, d)));
        check("R10 R11 mask reduced", 64'(rd_r), 64'(exp_after(a, 1'b1, d)));
      end
    end

    // R8 gap sweep over all 32 codes
    for (int v = 0; v < 32; v++) begin
      do_write(23, 32'(v));
      check("R8 ipg_eff full", 64'(ipg_f), 64'(exp_gap(v)));
      check("R10 ipg_eff reduced", 64'(ipg_r), 64'd12);
      do_read(23);
      check("R8 raw readback", 64'(rd_f), 64'(v));
    end

    // R9 latency clamp sweep
    for (int v = 0; v < 16; v++) begin
      do_write(14, 32'(v));
      check("R9 ready latency", 64'(lat_f), 64'((v < 3) ? 0 : (v > 11) ? 8 : v - 3));
      check("R10 reduced latency", 64'(lat_r), 64'd0);
      do_read(14);
      check("R9 raw readback", 64'(rd_f), 64'(v));
    end

    // R7 R12 station address packing
    do_write(3, 32'h1723_1C00);
    do_write(4, 32'h0000_CB4A);
    check("R7 station_addr", 64'(sa_f), 64'h0000_001C_2317_4ACB);
    do_write(6, 32'h0001_2345);
    check("R12 pause_quanta", 64'(pq_f), 64'h2345);
    do_write(15, 32'h0000_0013);
    check("R12 phy_addr0", 64'(p0_f), 64'h13);

    // R6 soft reset keeps other bits and registers
    do_write(2, 32'hFFFF_FFFF);
    do_write(5, 32'd1000);
    check("R6 tx_en set", 64'(txe_f), 64'd1);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R6 tx_en cleared", 64'(txe_f), 64'd0);
    check("R6 rx_en cleared", 64'(rxe_r), 64'd0);
    check("R6 cmd upper kept", 64'(cmd_f), 64'hFFFF_FFFC);
    check("R6 frame length kept", 64'(frm_f), 64'd1000);
    check("R6 station kept", 64'(sa_f), 64'h0000_001C_2317_4ACB);
    // soft reset racing a command write
    @(negedge clk);
    addr = 5'd2; wr_data = 32'h0000_00F3; wr_en = 1'b1; soft_rst = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; soft_rst = 1'b0;
    check("R6 race cmd", 64'(cmd_f), 64'h0000_00F0);

    // R1 read sees the word before a same-cycle write
    do_write(1, 32'h0000_0011);
    @(negedge clk);
    addr = 5'd1; wr_data = 32'h0000_0022; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R1 read before write", 64'(rd_f), 64'h11);
    @(negedge clk);
    check("R1 rd_valid drops", 64'(rv_f), 64'd0);
    do_read(1);
    check("R1 read after write", 64'(rd_f), 64'h22);
    check("R11 scratch reduced", 64'(rd_r), 64'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule